// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block sits behind the bus of a parallel NOR flash model and interprets the host's write cycles as command sequences. Most commands begin with a two-cycle unlock handshake. The block tracks the device mode: array read, identifier query, embedded program, sector erase, erase suspended, program within an erase suspend, failed operation, and write-buffer abort. When an embedded operation starts, is suspended or is resumed, the block raises a one-cycle pulse. It also presents the target address and data on its outputs.

Reads go through a registered read path. Depending on the mode, a read returns array contents, identifier and sector-protection codes, or a status word. An internal cycle counter stands in for the duration of each embedded operation. When the count completes, the mode drops back by itself.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Only bits 7..0 of the write data are decoded. Bits 15..8 have no effect on any unlock or command cycle.
- R2: After reset the mode is array read (code 0). In that mode a read returns `array_rdata` on `rd_data` one clock after `rd_en` is sampled.
- R3: The unlock handshake is data AAh at address 555h, then data 55h at address 2AAh. Only the low 11 address bits are compared. A write that is not the expected next step returns the decoder to its idle step and leaves the mode unchanged.
- R4: Unlock plus 90h at 555h enters identifier mode (code 1) from array read or erase suspend. In that mode, reads with address bits 1..0 set to 00 return `MFR_ID`, 01 returns `DEV_ID`, and 10 returns 0001h for a protected sector or 0000h for an unprotected one. The sector is the top `SECT_W` address bits, and protection is looked up in `PROT_MASK`.
- R5: A write of F0h leaves identifier mode for the mode it was entered from, and leaves the failed state (code 6) for array read.
- R6: Unlock plus A0h at 555h, followed by one address/data write, enters program mode (code 2) and pulses `start_prog`. Program mode lasts `PROG_CYC` cycles and then returns to array read. While it runs, status bit 7 reads as the complement of bit 7 of the programmed datum.
- R7: The sequence unlock, 80h, unlock, then 30h enters sector erase (code 3) and pulses `start_erase`. Erase mode lasts `ERASE_CYC` cycles in total, and cycles spent suspended are not counted. Status bit 7 reads 0 during erase.
- R8: A write of B0h moves sector erase to erase suspend (code 4) and pulses `erase_susp`. In any other mode it is ignored: the mode does not change and there is no pulse.
- R9: A write of 30h from the idle step in erase suspend resumes the erase and pulses `erase_resume`. In other modes it is ignored.
- R10: In erase suspend, reads of other sectors return array data and reads of the erasing sector return status with bit 7 set. A program to another sector runs in mode 5 and then returns to erase suspend. A program to the erasing sector is ignored.
- R11: `op_fail` during program or erase enters the failed state, where status bit 5 reads 1.
- R12: `buf_abort` during program enters the abort state (code 7), where status bit 1 reads 1 and bit 7 reads as in program mode. A lone F0h is ignored in this state; only unlock followed by F0h returns to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | One-cycle write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | 16 | Array contents at `rd_addr` |
| op_fail | input | 1 | Embedded operation failure report |
| buf_abort | input | 1 | Write-buffer abort report |
| rd_data | output | 16 | Registered read data |
| mode_o | output | 3 | Current mode code |
| start_prog | output | 1 | Program start pulse |
| start_erase | output | 1 | Erase start pulse |
| erase_susp | output | 1 | Erase suspend pulse |
| erase_resume | output | 1 | Erase resume pulse |
| op_addr | output | ADDR_W | Target address of the current operation |
| op_data | output | 16 | Datum being programmed |

## Verification
A mode change and its pulse appear on the clock edge that samples the final write of a sequence. The bench therefore checks both at the falling edge right after that write. Read data appears one edge after `rd_en`, and the bench samples it at the next falling edge. The embedded durations are counted in rising edges spent in the mode. The bench tallies the cycles it has used, including reads made while an erase runs. It then checks the mode one cycle before the expected completion and again on the completion cycle.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command byte values for the flash command decoder.
// Assumes: 16-bit data bus, commands carried in the low data byte.
package flash_cmd_pkg;
    typedef enum logic [2:0] {
        M_READ  = 3'd0,
        M_ASEL  = 3'd1,
        M_PROG  = 3'd2,
        M_ERASE = 3'd3,
        M_ESUSP = 3'd4,
        M_SPROG = 3'd5,
        M_ERR   = 3'd6,
        M_ABORT = 3'd7
    } fmode_t;

    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PADDR, S_ER1, S_ER2, S_ER3
    } fstep_t;

    typedef struct packed {
        logic rst_short;
        logic rst_full;
        logic asel;
        logic prog;
        logic erase;
        logic susp;
        logic resume;
    } fcmd_t;

    localparam logic [7:0] C_KEY_A  = 8'hAA;
    localparam logic [7:0] C_KEY_B  = 8'h55;
    localparam logic [7:0] C_RESET  = 8'hF0;
    localparam logic [7:0] C_QUERY  = 8'h90;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_ERSET  = 8'h80;
    localparam logic [7:0] C_GO     = 8'h30;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [10:0] ADR_KEY_A = 11'h555;
    localparam logic [10:0] ADR_KEY_B = 11'h2AA;
endpackage

// File: rtl/flash_cmd_seq.sv
// Write-cycle sequencer: follows the unlock/command steps and emits one
// decoded command per completing write. Purely syntactic; the caller
// decides whether the current mode accepts the command.
// Assumes: bus_we is a one-cycle strobe; UNLK_W <= ADDR_W and UNLK_W <= 11.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int UNLK_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output fcmd_t             cmd
);
    fstep_t     step, step_nxt;
    logic [7:0] cb;
    logic       at_a, at_b;

    assign cb   = wdata[7:0];
    assign at_a = addr[UNLK_W-1:0] == ADR_KEY_A[UNLK_W-1:0];
    assign at_b = addr[UNLK_W-1:0] == ADR_KEY_B[UNLK_W-1:0];

    // Decode the current write against the expected next step.
    always_comb begin
        cmd      = '0;
        step_nxt = step;
        if (we) begin
            step_nxt = S_IDLE;
            if (step == S_PADDR) begin
                cmd.prog = 1'b1;
            end else if (cb == C_SUSP) begin
                cmd.susp = 1'b1;
            end else begin
                case (step)
                    S_IDLE: begin
                        if (cb == C_KEY_A && at_a) step_nxt = S_UNL1;
                        else if (cb == C_RESET)    cmd.rst_short = 1'b1;
                        else if (cb == C_GO)       cmd.resume = 1'b1;
                    end
                    S_UNL1: begin
                        if (cb == C_KEY_B && at_b) step_nxt = S_UNL2;
                        else if (cb == C_RESET)    cmd.rst_short = 1'b1;
                    end
                    S_UNL2: begin
                        if (cb == C_QUERY && at_a)      cmd.asel = 1'b1;
                        else if (cb == C_PROG && at_a)  step_nxt = S_PADDR;
                        else if (cb == C_ERSET && at_a) step_nxt = S_ER1;
                        else if (cb == C_RESET)         cmd.rst_full = 1'b1;
                    end
                    S_ER1: begin
                        if (cb == C_KEY_A && at_a) step_nxt = S_ER2;
                        else if (cb == C_RESET)    cmd.rst_short = 1'b1;
                    end
                    S_ER2: begin
                        if (cb == C_KEY_B && at_b) step_nxt = S_ER3;
                        else if (cb == C_RESET)    cmd.rst_short = 1'b1;
                    end
                    S_ER3: begin
                        if (cb == C_GO)            cmd.erase = 1'b1;
                        else if (cb == C_RESET)    cmd.rst_short = 1'b1;
                    end
                    default: step_nxt = S_IDLE;
                endcase
            end
        end
    end

    // Hold the sequence step.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= S_IDLE;
        else        step <= step_nxt;
    end

    assert_padr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && step == S_PADDR) |=> step == S_IDLE);
    assert_unlock_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && step == S_UNL1 && wdata[7:0] != C_KEY_B) |=> step == S_IDLE);
endmodule

// File: rtl/flash_op_timer.sv
// Duration counters standing in for the embedded program and erase
// algorithms. The erase count is held while the erase is suspended.
// Assumes: PROG_CYC >= 2, ERASE_CYC >= 2.
module flash_op_timer #(
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_run,
    input  logic erase_run,
    input  logic erase_keep,
    output logic prog_done,
    output logic erase_done
);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam int EW = $clog2(ERASE_CYC + 1);

    logic [PW-1:0] p_cnt;
    logic [EW-1:0] e_cnt;

    assign prog_done  = prog_run  && (p_cnt == PW'(PROG_CYC - 1));
    assign erase_done = erase_run && (e_cnt == EW'(ERASE_CYC - 1));

    // Count program cycles; clear when idle or finished.
    always_ff @(posedge clk) begin
        if (!rst_n)                      p_cnt <= '0;
        else if (prog_run && !prog_done) p_cnt <= p_cnt + 1'b1;
        else                             p_cnt <= '0;
    end

    // Count erase cycles; hold across a suspension, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          e_cnt <= '0;
        else if (erase_run)  e_cnt <= erase_done ? '0 : e_cnt + 1'b1;
        else if (!erase_keep) e_cnt <= '0;
    end

    assert_prog_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        p_cnt < PW'(PROG_CYC));
    assert_erase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase_run && erase_keep) |=> $stable(e_cnt));
endmodule

// File: rtl/flash_rd_path.sv
// Registered read multiplexer: array data, identifier codes or status
// word, selected by the current mode.
// Status word: bit 7 data polling, bit 5 failure, bit 1 buffer abort.
module flash_rd_path
    import flash_cmd_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              SECT_W    = 3,
    parameter logic [15:0]     MFR_ID    = 16'h0001,
    parameter logic [15:0]     DEV_ID    = 16'h227E,
    parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 8'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       array_rdata,
    input  fmode_t            mode,
    input  logic [SECT_W-1:0] er_sect,
    input  logic              poll_d7,
    output logic [15:0]       rd_data
);
    logic [SECT_W-1:0] sect;
    logic [15:0]       rd_nxt;

    assign sect = rd_addr[ADDR_W-1 -: SECT_W];

    // Pick the read source for this mode.
    always_comb begin
        case (mode)
            M_READ: rd_nxt = array_rdata;
            M_ASEL: begin
                case (rd_addr[1:0])
                    2'b00:   rd_nxt = MFR_ID;
                    2'b01:   rd_nxt = DEV_ID;
                    2'b10:   rd_nxt = {15'd0, PROT_MASK[sect]};
                    default: rd_nxt = 16'h0000;
                endcase
            end
            M_PROG, M_SPROG: rd_nxt = {8'h00, ~poll_d7, 7'd0};
            M_ERASE:         rd_nxt = 16'h0000;
            M_ESUSP:         rd_nxt = (sect == er_sect) ? 16'h0080 : array_rdata;
            M_ERR:           rd_nxt = 16'h0020;
            M_ABORT:         rd_nxt = {8'h00, ~poll_d7, 5'd0, 1'b1, 1'b0};
            default:         rd_nxt = 16'h0000;
        endcase
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_nxt;
    end

    assert_array_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == M_READ) |=> rd_data == $past(array_rdata));
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the command decoder: qualifies decoded commands by the current
// mode, runs the mode machine, and drives the operation pulses.
// Assumes: op_fail and buf_abort are one-cycle reports from the embedded
// engine; a completion takes priority over a same-cycle command.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              SECT_W    = 3,
    parameter int              UNLK_W    = 11,
    parameter int              PROG_CYC  = 6,
    parameter int              ERASE_CYC = 20,
    parameter logic [15:0]     MFR_ID    = 16'h0001,
    parameter logic [15:0]     DEV_ID    = 16'h227E,
    parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 8'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       array_rdata,
    input  logic              op_fail,
    input  logic              buf_abort,
    output logic [15:0]       rd_data,
    output logic [2:0]        mode_o,
    output logic              start_prog,
    output logic              start_erase,
    output logic              erase_susp,
    output logic              erase_resume,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data
);
    fcmd_t             cmd;
    fmode_t            mode, mode_nxt, asel_ret;
    logic [SECT_W-1:0] er_sect, w_sect;
    logic              poll_d7;
    logic              go_prog, go_erase, go_susp, go_res, go_asel;
    logic              prog_done, erase_done, busy, any_rst;

    assign w_sect  = bus_addr[ADDR_W-1 -: SECT_W];
    assign busy    = (mode == M_PROG) || (mode == M_ERASE) || (mode == M_SPROG);
    assign any_rst = cmd.rst_short || cmd.rst_full;
    assign mode_o  = mode;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .UNLK_W(UNLK_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .cmd(cmd)
    );

    flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .prog_run((mode == M_PROG) || (mode == M_SPROG)),
        .erase_run(mode == M_ERASE),
        .erase_keep((mode == M_ESUSP) || (mode == M_SPROG) ||
                    (mode == M_ASEL && asel_ret == M_ESUSP)),
        .prog_done(prog_done), .erase_done(erase_done)
    );

    flash_rd_path #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .MFR_ID(MFR_ID),
                    .DEV_ID(DEV_ID), .PROT_MASK(PROT_MASK)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_rdata(array_rdata), .mode(mode), .er_sect(er_sect),
        .poll_d7(poll_d7), .rd_data(rd_data)
    );

    // Next mode: engine events first, then mode-qualified commands.
    always_comb begin
        mode_nxt = mode;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        go_susp  = 1'b0;
        go_res   = 1'b0;
        go_asel  = 1'b0;
        if (op_fail && busy) begin
            mode_nxt = M_ERR;
        end else if (buf_abort && mode == M_PROG) begin
            mode_nxt = M_ABORT;
        end else if (prog_done) begin
            mode_nxt = (mode == M_SPROG) ? M_ESUSP : M_READ;
        end else if (erase_done) begin
            mode_nxt = M_READ;
        end else begin
            if (any_rst && mode == M_ASEL)          mode_nxt = asel_ret;
            if (any_rst && mode == M_ERR)           mode_nxt = M_READ;
            if (cmd.rst_full && mode == M_ABORT)    mode_nxt = M_READ;
            if (cmd.asel && (mode == M_READ || mode == M_ESUSP)) begin
                mode_nxt = M_ASEL;
                go_asel  = 1'b1;
            end
            if (cmd.prog && mode == M_READ) begin
                mode_nxt = M_PROG;
                go_prog  = 1'b1;
            end
            if (cmd.prog && mode == M_ESUSP && w_sect != er_sect) begin
                mode_nxt = M_SPROG;
                go_prog  = 1'b1;
            end
            if (cmd.erase && mode == M_READ) begin
                mode_nxt = M_ERASE;
                go_erase = 1'b1;
            end
            if (cmd.susp && mode == M_ERASE) begin
                mode_nxt = M_ESUSP;
                go_susp  = 1'b1;
            end
            if (cmd.resume && mode == M_ESUSP) begin
                mode_nxt = M_ERASE;
                go_res   = 1'b1;
            end
        end
    end

    // Mode register, operation target capture and start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode         <= M_READ;
            asel_ret     <= M_READ;
            er_sect      <= '0;
            poll_d7      <= 1'b0;
            op_addr      <= '0;
            op_data      <= '0;
            start_prog   <= 1'b0;
            start_erase  <= 1'b0;
            erase_susp   <= 1'b0;
            erase_resume <= 1'b0;
        end else begin
            mode         <= mode_nxt;
            start_prog   <= go_prog;
            start_erase  <= go_erase;
            erase_susp   <= go_susp;
            erase_resume <= go_res;
            if (go_asel) asel_ret <= mode;
            if (go_prog) begin
                op_addr <= bus_addr;
                op_data <= bus_wdata;
                poll_d7 <= bus_wdata[7];
            end
            if (go_erase) begin
                op_addr <= bus_addr;
                er_sect <= w_sect;
            end
        end
    end

    assert_susp_from_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_susp |-> (mode == M_ESUSP && $past(mode) == M_ERASE));
    assert_resume_from_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_resume |-> (mode == M_ERASE && $past(mode) == M_ESUSP));
    assert_sprog_other_sector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog && mode == M_SPROG) |-> op_addr[ADDR_W-1 -: SECT_W] != er_sect);
    assert_err_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ERR) |=> (mode == M_ERR || mode == M_READ));
    assert_abort_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ABORT) |=> (mode == M_ABORT || mode == M_READ));
    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase, erase_susp, erase_resume}));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int PROG_CYC  = 6;
    localparam int ERASE_CYC = 20;
    localparam logic [7:0] PMASK = 8'h25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [15:0] array_rdata;
    logic        op_fail = 1'b0, buf_abort = 1'b0;
    logic [15:0] rd_data, op_addr, op_data;
    logic [2:0]  mode_o;
    logic        start_prog, start_erase, erase_susp, erase_resume;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    assign array_rdata = rd_addr ^ 16'hC3A5;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_rdata(array_rdata), .op_fail(op_fail), .buf_abort(buf_abort),
        .rd_data(rd_data), .mode_o(mode_o), .start_prog(start_prog),
        .start_erase(start_erase), .erase_susp(erase_susp),
        .erase_resume(erase_resume), .op_addr(op_addr), .op_data(op_data)
    );

    function automatic logic [15:0] arr_of(input logic [15:0] a);
        return a ^ 16'hC3A5;
    endfunction

    function automatic logic [15:0] prot_of(input logic [2:0] s);
        return {15'd0, PMASK[s]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] q);
        rd_addr = a;
        rd_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        q       = rd_data;
        rd_en   = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, {8'($urandom), 8'hAA});
        wr(16'h02AA, {8'($urandom), 8'h55});
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] q;
        void'($urandom(32'd1234));
        waitn(3);
        // R2 reset state
        chk("R2 reset mode", {13'd0, mode_o}, 16'd0);
        chk("R2 reset pulses", {12'd0, start_prog, start_erase, erase_susp, erase_resume}, 16'd0);
        rst_n = 1'b1;
        waitn(1);
        rd(16'h1234, q);
        chk("R2 array read", q, arr_of(16'h1234));

        // R3 wrong second unlock address, then query must not take effect
        wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055); wr(16'h0555, 16'h0090);
        chk("R3 bad unlock addr", {13'd0, mode_o}, 16'd0);
        unlock(); wr(16'h0555, 16'h0077); wr(16'h0555, 16'h0090);
        chk("R3 bad command byte", {13'd0, mode_o}, 16'd0);

        // R1 R4 identifier mode with noisy upper byte
        unlock(); wr(16'h0555, 16'h5A90);
        chk("R1 R4 enter identifier", {13'd0, mode_o}, 16'd1);
        rd(16'h0000, q); chk("R4 manufacturer code", q, 16'h0001);
        rd(16'h0001, q); chk("R4 device code", q, 16'h227E);
        rd(16'h4002, q); chk("R4 protected sector 2", q, 16'h0001);
        rd(16'h2002, q); chk("R4 unprotected sector 1", q, 16'h0000);
        wr(16'h0000, 16'hC3F0);
        chk("R5 reset from identifier", {13'd0, mode_o}, 16'd0);

        // R8 R9 suspend/resume ignored in array read
        wr(16'h0100, 16'h00B0);
        chk("R8 suspend ignored mode", {13'd0, mode_o}, 16'd0);
        chk("R8 suspend ignored pulse", {15'd0, erase_susp}, 16'd0);
        wr(16'h0100, 16'h0030);
        chk("R9 resume ignored mode", {13'd0, mode_o}, 16'd0);
        chk("R9 resume ignored pulse", {15'd0, erase_resume}, 16'd0);

        // R6 program
        unlock(); wr(16'h0555, 16'h00A0); wr(16'h4321, 16'hFF12);
        chk("R6 program mode", {13'd0, mode_o}, 16'd2);
        chk("R6 start pulse", {15'd0, start_prog}, 16'd1);
        chk("R6 target address", op_addr, 16'h4321);
        rd(16'h4321, q);
        chk("R6 polling bit complement", q, 16'h0080);
        waitn(PROG_CYC - 2);
        chk("R6 still programming", {13'd0, mode_o}, 16'd2);
        waitn(1);
        chk("R6 program done", {13'd0, mode_o}, 16'd0);

        // R7 sector erase of sector 5
        unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'hA000, 16'h7730);
        chk("R7 erase mode", {13'd0, mode_o}, 16'd3);
        chk("R7 start pulse", {15'd0, start_erase}, 16'd1);
        rd(16'h0000, q);
        chk("R7 erase status", q, 16'h0000);
        wr(16'h0000, 16'h00B0);
        chk("R8 suspended", {13'd0, mode_o}, 16'd4);
        chk("R8 suspend pulse", {15'd0, erase_susp}, 16'd1);
        wr(16'h0000, 16'h00B0);
        chk("R8 second suspend no pulse", {15'd0, erase_susp}, 16'd0);

        // R10 work during suspension
        rd(16'hA010, q); chk("R10 erasing sector status", q, 16'h0080);
        rd(16'h2010, q); chk("R10 other sector array", q, arr_of(16'h2010));
        unlock(); wr(16'h0555, 16'h00A0); wr(16'hA100, 16'h0001);
        chk("R10 program to erasing sector ignored", {13'd0, mode_o}, 16'd4);
        chk("R10 no start pulse", {15'd0, start_prog}, 16'd0);
        unlock(); wr(16'h0555, 16'h00A0); wr(16'h3000, 16'h00FF);
        chk("R10 suspend program", {13'd0, mode_o}, 16'd5);
        waitn(PROG_CYC - 1);
        chk("R10 suspend program running", {13'd0, mode_o}, 16'd5);
        waitn(1);
        chk("R10 back to suspended", {13'd0, mode_o}, 16'd4);
        unlock(); wr(16'h0555, 16'h0090);
        chk("R10 identifier in suspend", {13'd0, mode_o}, 16'd1);
        wr(16'h0000, 16'h00F0);
        chk("R5 identifier returns to suspend", {13'd0, mode_o}, 16'd4);

        // R9 resume: two erase cycles already used
        wr(16'h0000, 16'h0030);
        chk("R9 resumed", {13'd0, mode_o}, 16'd3);
        chk("R9 resume pulse", {15'd0, erase_resume}, 16'd1);
        waitn(ERASE_CYC - 2 - 1);
        chk("R7 erase remaining time", {13'd0, mode_o}, 16'd3);
        waitn(1);
        chk("R7 erase done", {13'd0, mode_o}, 16'd0);

        // R11 failure
        unlock(); wr(16'h0555, 16'h00A0); wr(16'h0200, 16'h0000);
        op_fail = 1'b1; waitn(1); op_fail = 1'b0;
        chk("R11 failed state", {13'd0, mode_o}, 16'd6);
        rd(16'h0200, q); chk("R11 failure status bit", q, 16'h0020);
        wr(16'h0000, 16'h00F0);
        chk("R5 reset from failure", {13'd0, mode_o}, 16'd0);

        // R12 buffer abort
        unlock(); wr(16'h0555, 16'h00A0); wr(16'h0300, 16'h0000);
        buf_abort = 1'b1; waitn(1); buf_abort = 1'b0;
        chk("R12 abort state", {13'd0, mode_o}, 16'd7);
        rd(16'h0300, q); chk("R12 abort status", q, 16'h0082);
        wr(16'h0000, 16'h00F0);
        chk("R12 lone reset ignored", {13'd0, mode_o}, 16'd7);
        unlock(); wr(16'h0000, 16'h00F0);
        chk("R12 unlocked reset exits", {13'd0, mode_o}, 16'd0);

        // R1 R2 R3 random writes that never start a sequence
        for (int i = 0; i < 30; i++) begin
            logic [15:0] a, d;
            a = 16'($urandom);
            d = 16'($urandom);
            if (d[7:0] == 8'hAA) d[7:0] = 8'h11;
            wr(a, d);
            chk("R3 random write no mode change", {13'd0, mode_o}, 16'd0);
            a = 16'($urandom);
            rd(a, q);
            chk("R2 random array read", q, arr_of(a));
        end

        // R1 R4 random sector protection queries
        for (int i = 0; i < 8; i++) begin
            logic [2:0] s;
            s = 3'($urandom);
            unlock(); wr(16'h0555, {8'($urandom), 8'h90});
            rd({s, 11'd0, 2'b10}, q);
            chk("R4 random protect query", q, prot_of(s));
            wr(16'($urandom), {8'($urandom), 8'hF0});
            chk("R1 R5 random reset", {13'd0, mode_o}, 16'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule